// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital half of a 10-bit successive-approximation analog-to-digital converter in a microcontroller peripheral. Software writes a control word carrying an enable bit, a start/busy bit and a justification bit. On a start, the sequencer opens the sample switch, which freezes the held voltage. It then walks a trial code down from the most significant bit to the least. It places each trial on an external DAC and keeps or drops the bit according to the comparator's answer.

Conversion timing comes from a conversion-clock tick. The tick is derived from the system clock by a selectable divider, or it is taken from an external enable. A finished conversion lands in a pair of 8-bit result bytes, justified left or right, and raises a sticky completion flag. Clearing the start/busy bit mid-conversion abandons the conversion and leaves the result bytes untouched. Either way the sequencer then waits two ticks before a new conversion may be started. While the converter is off, the two result bytes act as ordinary read/write storage.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The trial code starts at zero. The first tick after a start presents bit 9 alone. At each later tick the bit under trial is kept when `cmp_in` is 1 (input at or above the trial code) and cleared otherwise, and the next lower bit is added. With an ideal comparator the final code equals the input value.
- R2: A conversion takes 11 ticks. `busy` stays high through the first 10 ticks after the start write and falls at the 11th.
- R3: `hold_open` rises together with `busy` when a conversion starts. It is low whenever no conversion is running.
- R4: On completion, `busy` clears, `done_flag` sets, `hold_open` clears, and the result bytes are loaded one clock later.
- R5: A control write with the start bit at 0 during a conversion aborts it. The result bytes keep their previous contents and `done_flag` is not set.
- R6: After a completed or aborted conversion, start requests are ignored until two ticks have passed. A start after that is accepted.
- R7: With `wr_left`=1, result bits 9..2 go to `res_hi` and bits 1..0 go to `res_lo[7:6]`, with zeros below. With `wr_left`=0, bits 9..8 go to `res_hi[1:0]` and bits 7..0 go to `res_lo`, with zeros above.
- R8: With the converter off, writes to `res_hi`/`res_lo` through `res_hi_we`/`res_lo_we` are stored and read back unchanged.
- R9: A start bit carried in the same control write that turns the converter on is ignored.
- R10: `clk_sel` picks the tick source: 0 divides the clock by 2, 1 divides it by 8, 2 divides it by 32, and 3 uses the external `ext_tick` pulse.
- R11: `done_flag` stays set until `flag_clr` is pulsed.
- R12: Software writes to the result bytes during a conversion are accepted, and the completed result overwrites them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| wr_on | input | 1 | Control write: converter enable |
| wr_go | input | 1 | Control write: start (1) or abort (0) |
| wr_left | input | 1 | Control write: 1 left-justifies, 0 right-justifies |
| flag_clr | input | 1 | Clears the completion flag |
| res_hi_we | input | 1 | Software write strobe for the upper result byte |
| res_lo_we | input | 1 | Software write strobe for the lower result byte |
| wr_data | input | 8 | Data for result byte writes |
| clk_sel | input | 2 | Tick source select |
| ext_tick | input | 1 | External conversion-clock enable |
| cmp_in | input | 1 | Comparator decision: input >= trial code |
| dac_code | output | 10 | Trial code to the DAC |
| hold_open | output | 1 | Sample switch open (input disconnected) |
| busy | output | 1 | Start/busy bit readback |
| conv_on | output | 1 | Converter enable readback |
| done_flag | output | 1 | Sticky completion flag |
| res_hi | output | 8 | Upper result byte |
| res_lo | output | 8 | Lower result byte |

## Verification
A behavioural comparator answers against a held input value. Directed values such as 0x2B7, together with random 10-bit values, show whether every bit is decided in the right order: a swapped or skipped decision corrupts particular bit patterns. Random values under random justification separate the two packing layouts, because they put nonzero bits in the positions that must be zero. Hand-stepped external ticks pin down the 11-tick length, the two-tick settle window and the abort path. Measured conversion lengths under divide-by-8 and divide-by-32 tell the divider settings apart.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {ST_READY, ST_CONV, ST_SETTLE} seq_state_t;
  localparam logic [1:0] SEL_DIV_A = 2'd0;
  localparam logic [1:0] SEL_DIV_B = 2'd1;
  localparam logic [1:0] SEL_DIV_C = 2'd2;
  localparam logic [1:0] SEL_EXT   = 2'd3;
endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen import adc_seq_pkg::*; #(
  parameter int DIV_A = 2,
  parameter int DIV_B = 8,
  parameter int DIV_C = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] clk_sel,
  input  logic       ext_tick,
  output logic       tick
);
  localparam int CW = $clog2(DIV_C);
  localparam logic [CW-1:0] LIM_A = CW'(DIV_A - 1);
  localparam logic [CW-1:0] LIM_B = CW'(DIV_B - 1);
  localparam logic [CW-1:0] LIM_C = CW'(DIV_C - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  always_comb begin
    case (clk_sel)
      SEL_DIV_A: lim = LIM_A;
      SEL_DIV_B: lim = LIM_B;
      default:   lim = LIM_C;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (clk_sel == SEL_EXT) begin
      cnt  <= '0;
      tick <= ext_tick;
    end else if (cnt >= lim) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  assert_div_spacing_R10: assert property (@(posedge clk) disable iff (rst)
    (clk_sel != SEL_EXT && $stable(clk_sel) && tick) |=> !tick);
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core import adc_seq_pkg::*; #(
  parameter int RES_W      = 10,
  parameter int WAIT_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic             wr_on,
  input  logic             wr_go,
  input  logic             flag_clr,
  input  logic             tick,
  input  logic             cmp_in,
  output logic             on_q,
  output logic             go_q,
  output logic             hold_open,
  output logic             flag,
  output logic             done_pulse,
  output logic [RES_W-1:0] code,
  output logic [RES_W-1:0] result
);
  localparam int WC = $clog2(WAIT_TICKS) + 1;
  localparam logic [RES_W-1:0] TOP = RES_W'(1) << (RES_W - 1);
  localparam logic [WC-1:0] WLAST = WC'(WAIT_TICKS - 1);

  seq_state_t       state;
  logic [RES_W-1:0] mask;
  logic [WC-1:0]    wcnt;
  logic [RES_W-1:0] decided;
  logic             start_ok;
  logic             abort;

  assign decided  = cmp_in ? code : (code & ~mask);
  assign start_ok = ctl_we && wr_go && wr_on && on_q && !go_q && state == ST_READY;
  assign abort    = go_q && ctl_we && !wr_go;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_READY; on_q <= 1'b0; go_q <= 1'b0; hold_open <= 1'b0;
      flag <= 1'b0; done_pulse <= 1'b0; code <= '0; mask <= '0;
      wcnt <= '0; result <= '0;
    end else begin
      done_pulse <= 1'b0;
      if (ctl_we) on_q <= wr_on;
      if (flag_clr) flag <= 1'b0;
      if (ctl_we && !wr_on) begin
        state <= ST_READY; go_q <= 1'b0; hold_open <= 1'b0;
        mask <= '0; code <= '0;
      end else if (abort) begin
        state <= ST_SETTLE; wcnt <= '0; go_q <= 1'b0; hold_open <= 1'b0;
        mask <= '0; code <= '0;
      end else begin
        case (state)
          ST_READY: if (start_ok) begin
            state <= ST_CONV; go_q <= 1'b1; hold_open <= 1'b1;
            mask <= '0; code <= '0;
          end
          ST_CONV: if (tick) begin
            if (mask == '0) begin
              mask <= TOP; code <= TOP;
            end else if (mask[0]) begin
              result <= decided; done_pulse <= 1'b1; flag <= 1'b1;
              go_q <= 1'b0; hold_open <= 1'b0; state <= ST_SETTLE;
              wcnt <= '0; mask <= '0; code <= '0;
            end else begin
              mask <= mask >> 1;
              code <= decided | (mask >> 1);
            end
          end
          ST_SETTLE: if (tick) begin
            if (wcnt == WLAST) state <= ST_READY;
            else wcnt <= wcnt + 1'b1;
          end
          default: state <= ST_READY;
        endcase
      end
    end
  end

  assert_trial_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mask));
  assert_hold_in_conv_R3: assert property (@(posedge clk) disable iff (rst)
    hold_open |-> go_q);
  assert_flag_on_finish_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $fell(go_q));
  assert_abort_no_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (abort && !flag) |=> !flag);
  assert_settle_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SETTLE && ctl_we && wr_go && wr_on) |=> !go_q);
endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs #(
  parameter int RES_W  = 10,
  parameter int PAIR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic             wr_left,
  input  logic             load,
  input  logic [RES_W-1:0] result,
  input  logic             hi_we,
  input  logic             lo_we,
  input  logic [7:0]       wr_data,
  output logic [7:0]       res_hi,
  output logic [7:0]       res_lo
);
  localparam int PAD = PAIR_W - RES_W;

  logic              left_q;
  logic [PAIR_W-1:0] packed_val;

  assign packed_val = left_q ? {result, {PAD{1'b0}}} : {{PAD{1'b0}}, result};

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= 1'b0; res_hi <= '0; res_lo <= '0;
    end else begin
      if (ctl_we) left_q <= wr_left;
      if (load) begin
        res_hi <= packed_val[PAIR_W-1 -: 8];
        res_lo <= packed_val[7:0];
      end else begin
        if (hi_we) res_hi <= wr_data;
        if (lo_we) res_lo <= wr_data;
      end
    end
  end

  assert_left_zero_fill_R7: assert property (@(posedge clk) disable iff (rst)
    (load && left_q) |=> res_lo[5:0] == 6'd0);
  assert_right_zero_fill_R7: assert property (@(posedge clk) disable iff (rst)
    (load && !left_q) |=> res_hi[7:2] == 6'd0);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int RES_W      = 10,
  parameter int WAIT_TICKS = 2,
  parameter int DIV_A      = 2,
  parameter int DIV_B      = 8,
  parameter int DIV_C      = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic             wr_on,
  input  logic             wr_go,
  input  logic             wr_left,
  input  logic             flag_clr,
  input  logic             res_hi_we,
  input  logic             res_lo_we,
  input  logic [7:0]       wr_data,
  input  logic [1:0]       clk_sel,
  input  logic             ext_tick,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_code,
  output logic             hold_open,
  output logic             busy,
  output logic             conv_on,
  output logic             done_flag,
  output logic [7:0]       res_hi,
  output logic [7:0]       res_lo
);
  logic             tick;
  logic             done_pulse;
  logic [RES_W-1:0] result;

  adc_tick_gen #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_tick (
    .clk(clk), .rst(rst), .run(conv_on), .clk_sel(clk_sel),
    .ext_tick(ext_tick), .tick(tick));

  adc_sar_core #(.RES_W(RES_W), .WAIT_TICKS(WAIT_TICKS)) u_core (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .wr_on(wr_on), .wr_go(wr_go),
    .flag_clr(flag_clr), .tick(tick), .cmp_in(cmp_in), .on_q(conv_on),
    .go_q(busy), .hold_open(hold_open), .flag(done_flag),
    .done_pulse(done_pulse), .code(dac_code), .result(result));

  adc_result_regs #(.RES_W(RES_W), .PAIR_W(16)) u_res (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .wr_left(wr_left),
    .load(done_pulse), .result(result), .hi_we(res_hi_we),
    .lo_we(res_lo_we), .wr_data(wr_data), .res_hi(res_hi), .res_lo(res_lo));
endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_we = 0, wr_on = 0, wr_go = 0, wr_left = 0, flag_clr = 0;
  logic res_hi_we = 0, res_lo_we = 0, ext_tick = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] clk_sel = 0;
  logic [9:0] vin = 0;
  logic cmp_in;
  logic [9:0] dac_code;
  logic hold_open, busy, conv_on, done_flag;
  logic [7:0] res_hi, res_lo;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;
  assign cmp_in = (dac_code <= vin);

  adc_seq_ctrl u_dut (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .wr_on(wr_on), .wr_go(wr_go),
    .wr_left(wr_left), .flag_clr(flag_clr), .res_hi_we(res_hi_we),
    .res_lo_we(res_lo_we), .wr_data(wr_data), .clk_sel(clk_sel),
    .ext_tick(ext_tick), .cmp_in(cmp_in), .dac_code(dac_code),
    .hold_open(hold_open), .busy(busy), .conv_on(conv_on),
    .done_flag(done_flag), .res_hi(res_hi), .res_lo(res_lo));

  function automatic logic [15:0] pack_exp(input logic [9:0] v, input logic left);
    return left ? {v, 6'b0} : {6'b0, v};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctl_write(input logic on, input logic go, input logic left);
    @(negedge clk);
    ctl_we = 1; wr_on = on; wr_go = go; wr_left = left;
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic res_write(input logic hi, input logic [7:0] d);
    @(negedge clk);
    res_hi_we = hi; res_lo_we = !hi; wr_data = d;
    @(negedge clk);
    res_hi_we = 0; res_lo_we = 0;
  endtask

  task automatic pulse_flag_clr();
    @(negedge clk); flag_clr = 1;
    @(negedge clk); flag_clr = 0;
  endtask

  task automatic ext_pulse();
    ext_tick = 1;
    @(negedge clk); ext_tick = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (busy && n < 2000) begin
      @(negedge clk); n++;
    end
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    logic [9:0] v;
    logic lf;
    void'($urandom(32'h1A2B));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R4 reset busy", busy, 0);
    chk("R4 reset flag", done_flag, 0);
    chk("R3 reset hold", hold_open, 0);
    chk("R8 reset res", {res_hi, res_lo}, 16'h0);

    // R8: disabled, bytes are general storage
    res_write(1, 8'hA5); res_write(0, 8'h3C);
    @(negedge clk);
    chk("R8 hi rw", res_hi, 8'hA5);
    chk("R8 lo rw", res_lo, 8'h3C);

    // R9: start in enabling write ignored
    clk_sel = 2'd3;
    ctl_write(1, 1, 0);
    repeat (3) @(negedge clk);
    chk("R9 busy", busy, 0);
    chk("R9 hold", hold_open, 0);

    // R2/R1/R3/R4/R7: externally stepped conversion
    vin = 10'h2B7;
    ctl_write(1, 1, 0);
    chk("R3 hold on start", hold_open, 1);
    chk("R2 busy on start", busy, 1);
    chk("R1 first period code", dac_code, 0);
    ext_pulse();
    chk("R1 msb trial", dac_code, 10'h200);
    for (int i = 2; i <= 10; i++) ext_pulse();
    chk("R2 busy after 10 ticks", busy, 1);
    chk("R12 old result held", {res_hi, res_lo}, 16'hA53C);
    ext_pulse();
    chk("R2 busy after 11 ticks", busy, 0);
    chk("R4 flag", done_flag, 1);
    chk("R3 hold closed", hold_open, 0);
    chk("R7 right result", {res_hi, res_lo}, pack_exp(10'h2B7, 0));

    // R6: start during settle ignored
    ctl_write(1, 1, 0);
    @(negedge clk);
    chk("R6 start in settle ignored", busy, 0);
    ext_pulse(); ext_pulse();
    repeat (5) @(negedge clk);
    chk("R11 flag sticky", done_flag, 1);
    pulse_flag_clr();
    chk("R11 flag cleared", done_flag, 0);
    vin = 10'h155;
    ctl_write(1, 1, 0);
    chk("R6 start after settle", busy, 1);
    ext_pulse(); ext_pulse(); ext_pulse();
    // R5: abort
    ctl_write(1, 0, 0);
    repeat (3) @(negedge clk);
    chk("R5 busy cleared", busy, 0);
    chk("R5 no flag", done_flag, 0);
    chk("R5 result kept", {res_hi, res_lo}, pack_exp(10'h2B7, 0));
    chk("R5 hold closed", hold_open, 0);
    ctl_write(1, 1, 0);
    chk("R5 settle after abort", busy, 0);
    ext_pulse(); ext_pulse();

    // R1/R7/R12: random conversions at divide by 2
    clk_sel = 2'd0;
    for (int k = 0; k < 24; k++) begin
      v = 10'($urandom);
      if (k == 0) v = 10'h3FF;
      if (k == 1) v = 10'h000;
      lf = 1'($urandom);
      vin = v;
      repeat (10) @(negedge clk);
      pulse_flag_clr();
      ctl_write(1, 1, lf);
      chk("R6 random start", busy, 1);
      if (k % 4 == 2) begin
        res_write(1, 8'hEE); res_write(0, 8'h77);
        chk("R12 write in conv", {res_hi, res_lo}, 16'hEE77);
      end
      wait_done(n);
      chk("R1 R7 random result", {res_hi, res_lo}, pack_exp(v, lf));
      chk("R4 random flag", done_flag, 1);
    end

    // R10: divider lengths
    clk_sel = 2'd1;
    repeat (80) @(negedge clk);
    vin = 10'h0F0;
    ctl_write(1, 1, 1);
    wait_done(n);
    chk("R10 div8 length", (n >= 80 && n <= 91), 1);
    chk("R10 div8 result", {res_hi, res_lo}, pack_exp(10'h0F0, 1));
    clk_sel = 2'd2;
    repeat (200) @(negedge clk);
    ctl_write(1, 1, 0);
    wait_done(n);
    chk("R10 div32 length", (n >= 320 && n <= 355), 1);
    clk_sel = 2'd0;
    repeat (20) @(negedge clk);
    ctl_write(1, 1, 0);
    wait_done(n);
    chk("R10 div2 length", (n >= 20 && n <= 25), 1);

    // R8: disable and reuse storage
    ctl_write(0, 0, 0);
    res_write(1, 8'h5A); res_write(0, 8'hC3);
    @(negedge clk);
    chk("R8 disabled rw", {res_hi, res_lo}, 16'h5AC3);
    chk("R8 off", conv_on, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule